// File: doc/BRIEF.md
# MESI snooping line-state controller

This block keeps the coherence state of every line in a small write-back cache that uses invalidation and bus snooping. It sits between the processor-side request port and the shared bus. Processor reads, writes and evictions are answered as hits at once when the line state allows it. Otherwise the processor is stalled and one bus transaction is raised: read, read-exclusive, upgrade or write-back. That transaction is held until the bus acknowledges it.

Snooped transactions from other caches are answered in the cycle they appear. The block reports whether it holds the line and strobes a data supply: dirty data when the line was Modified, clean data when it was Exclusive. It then demotes or invalidates the line. A write to a line already held Shared raises only an upgrade. A write miss raises a read-exclusive. Owned data goes cache-to-cache instead of through memory. The data array, replacement, bus arbitration and memory ordering belong to neighbouring blocks.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset, every line is Invalid, and neither a bus request nor a supply strobe is asserted.
- R2: Each line's state is shown on `line_state_o`, two bits per line, with line i at bits [2i+1:2i]. The encoding is Invalid=00, Shared=01, Exclusive=10, Modified=11.
- R3: A processor read (op 0, and op 3 behaves as a read) to a line in S, E or M, or a write (op 1) to a line in E or M, raises `cpu_hit` in the same cycle with no bus request. A write hit on E leaves the line Modified after the clock edge. `cpu_hit` and `cpu_stall` are never high together while a request is valid.
- R4: A read to an Invalid line stalls the processor. From the next cycle on, it raises a bus request with op 0 (read), and the request index stays held until `bus_ack`. On the acknowledge the line becomes Shared if `bus_shared_in` is 1, or Exclusive if it is 0. While a request is outstanding, every processor request is stalled.
- R5: A write to a Shared line raises an upgrade (bus op 2). A write to an Invalid line raises a read-exclusive (bus op 1). Either way, the line is Modified after the acknowledge.
- R6: A snooped read (snoop op 0) to a valid line raises `snoop_shared_out`. A Modified line strobes `supply_valid` with `supply_dirty`=1 and becomes Shared. An Exclusive line strobes `supply_valid` with `supply_dirty`=0 and becomes Shared. A Shared line stays Shared without a strobe.
- R7: A snooped read-exclusive (op 1) or upgrade (op 2) leaves a valid line Invalid. A Modified line strobes a dirty supply. An Exclusive line strobes a clean supply on read-exclusive only. A Shared line gives no strobe.
- R8: An eviction (op 2) of a Shared or Exclusive line is a hit that leaves the line Invalid. Eviction of an Invalid line is a hit with no change. Eviction of a Modified line stalls, raises a write-back (bus op 3), and leaves the line Invalid after the acknowledge.
- R9: When a processor request and a snoop name the same line in the same cycle, the snoop is served and the processor is stalled for that cycle. When they name different lines, both are served.
- R10: If an upgrade is outstanding and a snoop invalidates the Shared copy, the bus request op changes to read-exclusive (op 1) from the next cycle.
- R11: A snooped write-back (op 3), or any snoop to an Invalid line, changes no state and gives no supply strobe. `snoop_shared_out` stays 0 for an Invalid line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_op | input | 2 | 0 read, 1 write, 2 evict, 3 read |
| cpu_req_idx | input | IDX_W | Line addressed by the processor |
| cpu_hit | output | 1 | Request completed this cycle |
| cpu_stall | output | 1 | Request not completed, must be retried |
| bus_req_valid | output | 1 | Bus transaction outstanding |
| bus_req_op | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| bus_req_idx | output | IDX_W | Line of the outstanding transaction |
| bus_ack | input | 1 | Outstanding transaction completed on the bus |
| bus_shared_in | input | 1 | Another cache holds the line (sampled with bus_ack) |
| snoop_valid | input | 1 | Snooped transaction present |
| snoop_op | input | 2 | Snooped op, same coding as bus_req_op |
| snoop_idx | input | IDX_W | Line addressed by the snoop |
| snoop_shared_out | output | 1 | This cache holds the snooped line |
| supply_valid | output | 1 | Line data is put on the bus this cycle |
| supply_dirty | output | 1 | Supplied data is dirty (memory must take it too) |
| line_state_o | output | 2*NUM_LINES | Packed state of all lines |

## Verification
Two sources can act on the same line in one cycle: a processor request and a snoop. The same holds for a pending upgrade and a snoop that steals its Shared copy. The bench provokes both on purpose, with a read that makes a line Exclusive followed by a write that meets a snooped read on that line. It also sends a snooped read-exclusive into the wait of an upgrade. Then it runs a long pseudo-random mix in which processor requests and snoops often land on the same index. A behavioural model judges every cycle: the snoop must take effect, the processor must see a stall, and the bus op must turn into read-exclusive the cycle after the copy is lost.

// File: rtl/mesi_pkg.sv
// Shared encodings for the MESI line-state controller.
// Assumes: state, bus-op and processor-op codes are 2 bits wide.
package mesi_pkg;

    // Line state encoding, visible on the state port.
    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } line_st_t;

    // Bus transaction codes, used for both issued and snooped ops.
    typedef enum logic [1:0] {
        BOP_RD   = 2'b00,
        BOP_RDX  = 2'b01,
        BOP_UPGR = 2'b10,
        BOP_WB   = 2'b11
    } bus_op_t;

    // Processor request codes (code 3 behaves as a read).
    typedef enum logic [1:0] {
        COP_READ  = 2'b00,
        COP_WRITE = 2'b01,
        COP_EVICT = 2'b10
    } cpu_op_t;

endpackage

// File: rtl/mesi_snoop_unit.sv
// Snoop responder: decides the reply to one snooped op for the addressed line.
// Assumes: cur_st is the current state of the snooped line; purely combinational.
module mesi_snoop_unit
    import mesi_pkg::*;
(
    input  logic       snp_valid,
    input  logic [1:0] snp_op,
    input  logic [1:0] cur_st,
    output logic       shared_o,
    output logic       sup_valid_o,
    output logic       sup_dirty_o,
    output logic       upd_en_o,
    output logic [1:0] upd_st_o
);

    logic owned;
    assign owned = (cur_st == ST_M) || (cur_st == ST_E);

    // Snoop reply and demotion for the snooped line.
    always_comb begin
        shared_o    = snp_valid && (cur_st != ST_I);
        sup_valid_o = 1'b0;
        sup_dirty_o = 1'b0;
        upd_en_o    = 1'b0;
        upd_st_o    = cur_st;
        if (snp_valid && (cur_st != ST_I)) begin
            unique case (snp_op)
                BOP_RD: begin
                    if (owned) begin
                        sup_valid_o = 1'b1;
                        sup_dirty_o = (cur_st == ST_M);
                        upd_en_o    = 1'b1;
                        upd_st_o    = ST_S;
                    end
                end
                BOP_RDX: begin
                    sup_valid_o = owned;
                    sup_dirty_o = (cur_st == ST_M);
                    upd_en_o    = 1'b1;
                    upd_st_o    = ST_I;
                end
                BOP_UPGR: begin
                    sup_valid_o = (cur_st == ST_M);
                    sup_dirty_o = (cur_st == ST_M);
                    upd_en_o    = 1'b1;
                    upd_st_o    = ST_I;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/mesi_req_unit.sv
// Processor-side sequencer: classifies requests as hit or miss, holds one
// outstanding bus transaction and installs the line on acknowledge.
// Assumes: cpu_line_st is the state of cpu_req_idx, pend_line_st the state of
// the pending line; collide is high when a snoop names the processor's line.
module mesi_req_unit
    import mesi_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req_valid,
    input  logic [1:0]       cpu_req_op,
    input  logic [IDX_W-1:0] cpu_req_idx,
    input  logic [1:0]       cpu_line_st,
    input  logic [1:0]       pend_line_st,
    input  logic             collide,
    input  logic             bus_ack,
    input  logic             bus_shared_in,
    output logic             cpu_hit,
    output logic             cpu_stall,
    output logic             bus_req_valid,
    output logic [1:0]       bus_req_op,
    output logic [IDX_W-1:0] bus_req_idx,
    output logic             hit_upd_en,
    output logic [1:0]       hit_upd_st,
    output logic             ack_upd_en,
    output logic [1:0]       ack_upd_st
);

    logic             busy_q;
    logic [1:0]       pend_op_q;
    logic [IDX_W-1:0] pend_idx_q;
    logic             is_write;
    logic             is_evict;
    logic             need_bus;
    logic             can_go;
    logic             capture;

    // Request classification against the current line state.
    always_comb begin
        is_write = (cpu_req_op == COP_WRITE);
        is_evict = (cpu_req_op == COP_EVICT);
        if (is_write)
            need_bus = (cpu_line_st == ST_I) || (cpu_line_st == ST_S);
        else if (is_evict)
            need_bus = (cpu_line_st == ST_M);
        else
            need_bus = (cpu_line_st == ST_I);
        can_go     = cpu_req_valid && !busy_q && !collide;
        cpu_hit    = can_go && !need_bus;
        cpu_stall  = cpu_req_valid && !cpu_hit;
        capture    = can_go && need_bus;
        hit_upd_en = cpu_hit && ((is_write && (cpu_line_st == ST_E)) ||
                                 (is_evict && (cpu_line_st != ST_I)));
        hit_upd_st = is_write ? ST_M : ST_I;
    end

    // Bus op follows the pending line's present state, so a lost copy turns an upgrade into read-exclusive.
    always_comb begin
        unique case (pend_op_q)
            COP_WRITE: bus_req_op = (pend_line_st == ST_S) ? BOP_UPGR : BOP_RDX;
            COP_EVICT: bus_req_op = BOP_WB;
            default:   bus_req_op = BOP_RD;
        endcase
        ack_upd_en = busy_q && bus_ack;
        if (pend_op_q == COP_WRITE)
            ack_upd_st = ST_M;
        else if (pend_op_q == COP_EVICT)
            ack_upd_st = ST_I;
        else
            ack_upd_st = bus_shared_in ? ST_S : ST_E;
    end

    // Outstanding-transaction register: set on a miss, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            pend_op_q  <= COP_READ;
            pend_idx_q <= '0;
        end else if (capture) begin
            busy_q     <= 1'b1;
            pend_op_q  <= cpu_req_op;
            pend_idx_q <= cpu_req_idx;
        end else if (ack_upd_en) begin
            busy_q     <= 1'b0;
        end
    end

    assign bus_req_valid = busy_q;
    assign bus_req_idx   = pend_idx_q;

endmodule

// File: rtl/mesi_line_array.sv
// State store: one 2-bit register per line with three update ports.
// Assumes: priority acknowledge > snoop > processor hit when ports name one line.
module mesi_line_array
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ack_en,
    input  logic [IDX_W-1:0]          ack_idx,
    input  logic [1:0]                ack_st,
    input  logic                      snp_en,
    input  logic [IDX_W-1:0]          snp_idx,
    input  logic [1:0]                snp_st,
    input  logic                      hit_en,
    input  logic [IDX_W-1:0]          hit_idx,
    input  logic [1:0]                hit_st,
    output logic [NUM_LINES-1:0][1:0] lines_o
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Per-line state register with prioritised update.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lines_o[g] <= ST_I;
            else if (ack_en && (ack_idx == IDX_W'(g)))
                lines_o[g] <= ack_st;
            else if (snp_en && (snp_idx == IDX_W'(g)))
                lines_o[g] <= snp_st;
            else if (hit_en && (hit_idx == IDX_W'(g)))
                lines_o[g] <= hit_st;
        end
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
// MESI line-state controller top: ties the state store, the snoop responder
// and the processor-side sequencer together.
// Assumes: NUM_LINES is a power of two (at least 2); the bus never acknowledges
// the pending transaction in the same cycle as a snoop to that same line.
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter  int NUM_LINES = 4,
    localparam int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req_valid,
    input  logic [1:0]             cpu_req_op,
    input  logic [IDX_W-1:0]       cpu_req_idx,
    output logic                   cpu_hit,
    output logic                   cpu_stall,
    output logic                   bus_req_valid,
    output logic [1:0]             bus_req_op,
    output logic [IDX_W-1:0]       bus_req_idx,
    input  logic                   bus_ack,
    input  logic                   bus_shared_in,
    input  logic                   snoop_valid,
    input  logic [1:0]             snoop_op,
    input  logic [IDX_W-1:0]       snoop_idx,
    output logic                   snoop_shared_out,
    output logic                   supply_valid,
    output logic                   supply_dirty,
    output logic [2*NUM_LINES-1:0] line_state_o
);

    logic [NUM_LINES-1:0][1:0] lines;
    logic [1:0]                cpu_line_st;
    logic [1:0]                snp_line_st;
    logic [1:0]                pend_line_st;
    logic                      collide;
    logic                      snp_upd_en;
    logic [1:0]                snp_upd_st;
    logic                      hit_upd_en;
    logic [1:0]                hit_upd_st;
    logic                      ack_upd_en;
    logic [1:0]                ack_upd_st;

    // Read ports into the state store and same-line detection.
    always_comb begin
        cpu_line_st  = lines[cpu_req_idx];
        snp_line_st  = lines[snoop_idx];
        pend_line_st = lines[bus_req_idx];
        collide      = snoop_valid && cpu_req_valid && (snoop_idx == cpu_req_idx);
    end

    mesi_snoop_unit u_snoop (
        .snp_valid   (snoop_valid),
        .snp_op      (snoop_op),
        .cur_st      (snp_line_st),
        .shared_o    (snoop_shared_out),
        .sup_valid_o (supply_valid),
        .sup_dirty_o (supply_dirty),
        .upd_en_o    (snp_upd_en),
        .upd_st_o    (snp_upd_st)
    );

    mesi_req_unit #(.IDX_W(IDX_W)) u_req (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_op    (cpu_req_op),
        .cpu_req_idx   (cpu_req_idx),
        .cpu_line_st   (cpu_line_st),
        .pend_line_st  (pend_line_st),
        .collide       (collide),
        .bus_ack       (bus_ack),
        .bus_shared_in (bus_shared_in),
        .cpu_hit       (cpu_hit),
        .cpu_stall     (cpu_stall),
        .bus_req_valid (bus_req_valid),
        .bus_req_op    (bus_req_op),
        .bus_req_idx   (bus_req_idx),
        .hit_upd_en    (hit_upd_en),
        .hit_upd_st    (hit_upd_st),
        .ack_upd_en    (ack_upd_en),
        .ack_upd_st    (ack_upd_st)
    );

    mesi_line_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_en  (ack_upd_en),
        .ack_idx (bus_req_idx),
        .ack_st  (ack_upd_st),
        .snp_en  (snp_upd_en),
        .snp_idx (snoop_idx),
        .snp_st  (snp_upd_st),
        .hit_en  (hit_upd_en),
        .hit_idx (cpu_req_idx),
        .hit_st  (hit_upd_st),
        .lines_o (lines)
    );

    assign line_state_o = lines;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
// Protocol checker for mesi_line_ctrl, attached by bind; observes ports only.
// Assumes: same parameters as the controller it watches.
module mesi_line_ctrl_chk
    import mesi_pkg::*;
#(
    parameter  int NUM_LINES = 4,
    localparam int IDX_W     = $clog2(NUM_LINES)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cpu_req_valid,
    input logic                   cpu_hit,
    input logic                   cpu_stall,
    input logic                   bus_req_valid,
    input logic [1:0]             bus_req_op,
    input logic [IDX_W-1:0]       bus_req_idx,
    input logic                   bus_ack,
    input logic                   snoop_valid,
    input logic [1:0]             snoop_op,
    input logic [IDX_W-1:0]       snoop_idx,
    input logic                   supply_valid,
    input logic                   supply_dirty,
    input logic [2*NUM_LINES-1:0] line_state_o
);

    AST_HIT_XOR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid |-> ($countones({cpu_hit, cpu_stall}) == 1)); // R3

    AST_NO_HIT_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> !cpu_hit); // R4

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_ack) |=> (bus_req_valid && $stable(bus_req_idx))); // R4

    AST_SUPPLY_ON_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        supply_valid |-> (snoop_valid && (snoop_op != BOP_WB))); // R6

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        AST_SNOOP_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
            (snoop_valid && (snoop_idx == IDX_W'(g)) &&
             ((snoop_op == BOP_RDX) || (snoop_op == BOP_UPGR)) &&
             !(bus_req_valid && bus_ack && (bus_req_idx == IDX_W'(g))))
            |=> (line_state_o[2*g +: 2] == ST_I)); // R7

        AST_WRITE_ACK_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_req_valid && bus_ack && (bus_req_idx == IDX_W'(g)) &&
             ((bus_req_op == BOP_RDX) || (bus_req_op == BOP_UPGR)))
            |=> (line_state_o[2*g +: 2] == ST_M)); // R5

        AST_DIRTY_FROM_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
            (snoop_valid && (snoop_idx == IDX_W'(g)) && (snoop_op != BOP_WB) &&
             (line_state_o[2*g +: 2] == ST_M))
            |-> (supply_valid && supply_dirty)); // R6

        AST_NO_UPGRADE_FROM_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_req_valid && (bus_req_idx == IDX_W'(g)) &&
             (line_state_o[2*g +: 2] == ST_I))
            |-> (bus_req_op != BOP_UPGR)); // R10
    end

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_hit       (cpu_hit),
    .cpu_stall     (cpu_stall),
    .bus_req_valid (bus_req_valid),
    .bus_req_op    (bus_req_op),
    .bus_req_idx   (bus_req_idx),
    .bus_ack       (bus_ack),
    .snoop_valid   (snoop_valid),
    .snoop_op      (snoop_op),
    .snoop_idx     (snoop_idx),
    .supply_valid  (supply_valid),
    .supply_dirty  (supply_dirty),
    .line_state_o  (line_state_o)
);

// File: tb/mesi_line_ctrl_bench.sv
// Bench for mesi_line_ctrl: directed scenarios, then a pseudo-random mix,
// all judged every cycle against a behavioural reference model.
module mesi_line_ctrl_bench;

    localparam int NL   = 4;
    localparam int IW   = 2;
    localparam int SI   = 0;
    localparam int SS   = 1;
    localparam int SE   = 2;
    localparam int SM   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cpu_req_valid = 1'b0;
    logic [1:0]      cpu_req_op = 2'd0;
    logic [IW-1:0]   cpu_req_idx = '0;
    logic            cpu_hit;
    logic            cpu_stall;
    logic            bus_req_valid;
    logic [1:0]      bus_req_op;
    logic [IW-1:0]   bus_req_idx;
    logic            bus_ack = 1'b0;
    logic            bus_shared_in = 1'b0;
    logic            snoop_valid = 1'b0;
    logic [1:0]      snoop_op = 2'd0;
    logic [IW-1:0]   snoop_idx = '0;
    logic            snoop_shared_out;
    logic            supply_valid;
    logic            supply_dirty;
    logic [2*NL-1:0] line_state_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1 reset";

    int m_st [NL];
    int m_busy = 0;
    int m_pop  = 0;
    int m_pidx = 0;

    always #10 clk = ~clk;

    mesi_line_ctrl #(.NUM_LINES(NL)) u_mesi_line_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .cpu_req_valid    (cpu_req_valid),
        .cpu_req_op       (cpu_req_op),
        .cpu_req_idx      (cpu_req_idx),
        .cpu_hit          (cpu_hit),
        .cpu_stall        (cpu_stall),
        .bus_req_valid    (bus_req_valid),
        .bus_req_op       (bus_req_op),
        .bus_req_idx      (bus_req_idx),
        .bus_ack          (bus_ack),
        .bus_shared_in    (bus_shared_in),
        .snoop_valid      (snoop_valid),
        .snoop_op         (snoop_op),
        .snoop_idx        (snoop_idx),
        .snoop_shared_out (snoop_shared_out),
        .supply_valid     (supply_valid),
        .supply_dirty     (supply_dirty),
        .line_state_o     (line_state_o)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s / %s: actual %0d expected %0d at %0t", phase, what, act, exp, $time);
        end
    endtask

    // Reference model: compare at the falling edge, then advance to the post-edge state.
    always @(negedge clk) begin
        if (!rst_n) begin
            foreach (m_st[i]) m_st[i] = SI;
            m_busy = 0;
            m_pop  = 0;
            m_pidx = 0;
        end else begin
            int  cs, ss, e_op, nst, ci, si;
            bit  coll, miss, e_hit, e_sup, e_dirty, wr, ev;
            ci   = int'(cpu_req_idx);
            si   = int'(snoop_idx);
            cs   = m_st[ci];
            ss   = m_st[si];
            wr   = (cpu_req_op == 2'd1);
            ev   = (cpu_req_op == 2'd2);
            coll = snoop_valid && cpu_req_valid && (si == ci);
            if (wr)      miss = (cs == SI) || (cs == SS);
            else if (ev) miss = (cs == SM);
            else         miss = (cs == SI);
            e_hit = cpu_req_valid && !m_busy && !coll && !miss;
            chk("R3 cpu_hit", int'(cpu_hit), int'(e_hit));
            chk("R3 cpu_stall", int'(cpu_stall), int'(cpu_req_valid && !e_hit));
            chk("R4 bus_req_valid", int'(bus_req_valid), m_busy);
            if (m_busy != 0) begin
                if (m_pop == 1)      e_op = (m_st[m_pidx] == SS) ? 2 : 1;
                else if (m_pop == 2) e_op = 3;
                else                 e_op = 0;
                chk("R5 R10 bus_req_op", int'(bus_req_op), e_op);
                chk("R4 bus_req_idx", int'(bus_req_idx), m_pidx);
            end
            chk("R6 snoop_shared_out", int'(snoop_shared_out), int'(snoop_valid && ss != SI));
            e_sup = 0; e_dirty = 0; nst = ss;
            if (snoop_valid && ss != SI) begin
                if (snoop_op == 2'd0) begin
                    if (ss == SM || ss == SE) begin e_sup = 1; e_dirty = (ss == SM); nst = SS; end
                end else if (snoop_op == 2'd1) begin
                    e_sup = (ss == SM || ss == SE); e_dirty = (ss == SM); nst = SI;
                end else if (snoop_op == 2'd2) begin
                    e_sup = (ss == SM); e_dirty = (ss == SM); nst = SI;
                end
            end
            chk("R7 R11 supply_valid", int'(supply_valid), int'(e_sup));
            if (e_sup) chk("R6 supply_dirty", int'(supply_dirty), int'(e_dirty));
            for (int i = 0; i < NL; i++)
                chk("R2 line state", int'(line_state_o[2*i +: 2]), m_st[i]);
            // advance the model
            if (snoop_valid) m_st[si] = nst;
            if (e_hit) begin
                if (wr && cs == SE) m_st[ci] = SM;
                if (ev) m_st[ci] = SI;
            end
            if (m_busy != 0 && bus_ack) begin
                if (m_pop == 1)      m_st[m_pidx] = SM;
                else if (m_pop == 2) m_st[m_pidx] = SI;
                else                 m_st[m_pidx] = bus_shared_in ? SS : SE;
                m_busy = 0;
            end else if (cpu_req_valid && !m_busy && !coll && miss) begin
                m_busy = 1;
                m_pop  = int'(cpu_req_op);
                m_pidx = ci;
            end
        end
    end

    // One cycle of stimulus: apply inputs, then wait past the next rising edge.
    task automatic cyc(input bit cv, input int cop, input int cidx,
                       input bit sv, input int sop, input int sidx,
                       input bit ack, input bit sh);
        cpu_req_valid = cv;
        cpu_req_op    = 2'(cop);
        cpu_req_idx   = IW'(cidx);
        snoop_valid   = sv;
        snoop_op      = 2'(sop);
        snoop_idx     = IW'(sidx);
        bus_ack       = ack;
        bus_shared_in = sh;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // Processor op on one line through its bus transaction, acknowledged with shared flag sh.
    task automatic cpu_miss(input int cop, input int idx, input bit sh);
        cyc(1, cop, idx, 0, 0, 0, 0, 0);
        cyc(1, cop, idx, 0, 0, 0, 0, 0);
        cyc(1, cop, idx, 0, 0, 0, 1, sh);
        cyc(1, cop, idx, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        phase = "R1 reset";
        chk("R1 states all invalid", int'(line_state_o), 0);
        chk("R1 no bus request", int'(bus_req_valid), 0);
        chk("R1 no supply", int'(supply_valid), 0);
        @(posedge clk); #1;

        phase = "R4 read miss exclusive";
        cpu_miss(0, 0, 0);
        phase = "R4 read miss shared";
        cpu_miss(0, 1, 1);
        phase = "R3 write hit on E";
        cyc(1, 1, 0, 0, 0, 0, 0, 0);
        cyc(1, 3, 0, 0, 0, 0, 0, 0);
        phase = "R5 upgrade from S";
        cpu_miss(1, 1, 0);
        phase = "R5 read-exclusive from I";
        cpu_miss(1, 2, 1);
        phase = "R6 snoop read on M";
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
        phase = "R6 snoop read on E";
        cpu_miss(0, 3, 0);
        cyc(0, 0, 0, 1, 0, 3, 0, 0);
        cyc(0, 0, 0, 1, 0, 3, 0, 0);
        phase = "R7 snoop rdx on M";
        cyc(0, 0, 0, 1, 1, 1, 0, 0);
        phase = "R7 snoop upgrade on S";
        cyc(0, 0, 0, 1, 2, 0, 0, 0);
        cyc(0, 0, 0, 1, 1, 3, 0, 0);
        phase = "R8 evict M write-back";
        cpu_miss(2, 2, 0);
        phase = "R8 evict E and I";
        cpu_miss(0, 0, 0);
        cyc(1, 2, 0, 0, 0, 0, 0, 0);
        cyc(1, 2, 0, 0, 0, 0, 0, 0);
        phase = "R9 same-line collision";
        cpu_miss(0, 1, 0);
        cyc(1, 1, 1, 1, 0, 1, 0, 0);
        cyc(1, 0, 1, 0, 0, 0, 0, 0);
        phase = "R9 different-line pair";
        cpu_miss(0, 3, 0);
        cyc(1, 1, 3, 1, 0, 1, 0, 0);
        phase = "R10 upgrade loses copy";
        cyc(1, 1, 1, 0, 0, 0, 0, 0);
        cyc(1, 1, 1, 1, 1, 1, 0, 0);
        cyc(1, 1, 1, 0, 0, 0, 0, 0);
        cyc(1, 1, 1, 0, 0, 0, 1, 0);
        cyc(1, 1, 1, 0, 0, 0, 0, 0);
        phase = "R11 ignored snoops";
        cyc(0, 0, 0, 1, 3, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 2, 0, 0);
        cyc(0, 0, 0, 1, 1, 0, 0, 0);
        idle();

        phase = "R9 random mix";
        for (int n = 0; n < 4000; n++) begin
            bit cv, sv, ack;
            int sidx;
            cv   = ($urandom % 4) != 0;
            sv   = ($urandom % 3) == 0;
            sidx = int'($urandom % NL);
            ack  = ($urandom % 3) == 0;
            if (sv && m_busy != 0 && sidx == m_pidx) ack = 0;
            cyc(cv, int'($urandom % 4), int'($urandom % NL), sv, int'($urandom % 4), sidx,
                ack, bit'($urandom % 2));
        end
        idle();
        idle();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule